// File: doc/BRIEF.md
# Load-Store Address Dependency Checker

This block decides, cycle by cycle, whether a load may begin its memory read. It keeps the effective addresses of the stores that are in flight but not yet committed. The stores are held in program order in a small ring, and each carries an age tag. A load presents its address and its age. The load is granted only when no store older than it either still lacks an address or already holds an address equal to the load's. Stores update memory only when they commit, one at a time and in order. For that reason write-after-write and write-after-read ordering through memory needs no check here. Only read-after-write ordering is enforced.

A store is allocated with its age before its address is known. The address is filled in later by age. A commit removes the oldest store. A flush carries a boundary age and drops every store younger than that boundary. The load decision is combinational on the registered queue state, so a change made at a clock edge shows in the decision during the following cycle. Ages wrap around and are compared modulo 2^AGE_W.

Top module: `ldst_dep_check`

## Requirements
- R1: After reset the queue is empty: `sq_count` is 0, `sq_full` is 0, and any valid load is granted.
- R2: An allocation adds one store with an unknown address, and `sq_count` rises by one at the next edge. An allocation made while `sq_full` is 1 (count equal to DEPTH) is ignored.
- R3: A valid load with an older store whose address is still unknown is not granted, and `ld_stall_unknown` is 1.
- R4: A valid load with an older store whose known address equals `ld_addr` is not granted, and `ld_stall_match` is 1.
- R5: Stores younger than the load never block it, whether their addresses are unknown or matching.
- R6: An address fill names a queued store by age and marks its address known. The load decision reflects the fill starting in the cycle after the edge. A fill naming an age that is not queued is ignored.
- R7: A commit removes the oldest store and lowers `sq_count` by one. A commit on an empty queue is ignored. A store is committed only after its address is known.
- R8: A flush removes every store strictly younger than `flush_age`, and keeps stores at that age or older. An allocation or fill in the same cycle as a flush is ignored.
- R9: Age a is older than age b when (a - b) mod 2^AGE_W has its top bit set, so the comparison stays correct across wraparound.
- R10: When `ld_valid` is 0, `ld_grant`, `ld_stall_unknown` and `ld_stall_match` are all 0.
- R11: An older store with a known address different from `ld_addr` does not block the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_valid | input | 1 | Allocate a store at the tail |
| st_alloc_age | input | AGE_W | Age of the store being allocated |
| st_addr_valid | input | 1 | Address fill for a queued store |
| st_addr_age | input | AGE_W | Age naming the store being filled |
| st_addr | input | ADDR_W | Effective address of that store |
| st_commit | input | 1 | Oldest store commits and leaves |
| flush_valid | input | 1 | Drop stores younger than the boundary |
| flush_age | input | AGE_W | Flush boundary age |
| ld_valid | input | 1 | A load asks for a decision |
| ld_age | input | AGE_W | Age of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| ld_grant | output | 1 | Load may start its memory read |
| ld_stall_unknown | output | 1 | An older store has an unknown address |
| ld_stall_match | output | 1 | An older store has a matching address |
| sq_count | output | $clog2(DEPTH+1) | Number of queued stores |
| sq_full | output | 1 | Queue holds DEPTH stores |

## Verification
The assertions rely on three assumptions about the inputs. Ages in flight must span less than half the age space. A commit must only come when the oldest store's address is known. Allocated ages must be younger than every store already queued.

The stimulus meets these assumptions as follows. Stores are given even ages that rise by two, and loads are given odd ages that fall between queued stores. The oldest store is committed only after its fill. After a flush, the next store age restarts just past the boundary. Addresses are drawn from a pool of four values so that matches happen often. The ages wrap many times during a run, and directed cases place stores on both sides of the wrap point.

// File: rtl/ldst_dep_pkg.sv
package ldst_dep_pkg;

   // True when age a precedes age b, modulo 2^w (w <= 32).
   function automatic logic age_older(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input int unsigned w);
      logic [31:0] diff;
      diff = a - b;
      return diff[w-1];
   endfunction

endpackage

// File: rtl/sq_entry_hazard.sv
module sq_entry_hazard
   import ldst_dep_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int AGE_W  = 6
) (
   input  logic              ent_valid,
   input  logic              ent_known,
   input  logic [ADDR_W-1:0] ent_addr,
   input  logic [AGE_W-1:0]  ent_age,
   input  logic [AGE_W-1:0]  ld_age,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              hz_unknown,
   output logic              hz_match
);

   logic st_is_older;
   logic same_addr;

   always_comb begin
      st_is_older = age_older(32'(ent_age), 32'(ld_age), AGE_W);
      same_addr   = (ent_addr == ld_addr);
      hz_unknown  = ent_valid & st_is_older & ~ent_known;
      hz_match    = ent_valid & st_is_older & ent_known & same_addr;
   end

endmodule

// File: rtl/sq_store_ring.sv
module sq_store_ring
   import ldst_dep_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int AGE_W  = 6,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_valid,
   input  logic [AGE_W-1:0]             alloc_age,
   input  logic                         fill_valid,
   input  logic [AGE_W-1:0]             fill_age,
   input  logic [ADDR_W-1:0]            fill_addr,
   input  logic                         commit_valid,
   input  logic                         flush_valid,
   input  logic [AGE_W-1:0]             flush_age,
   output logic [DEPTH-1:0]             ent_valid,
   output logic [DEPTH-1:0]             ent_known,
   output logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
   output logic [DEPTH-1:0][AGE_W-1:0]  ent_age,
   output logic [CNT_W-1:0]             count,
   output logic                         full
);

   logic [DEPTH-1:0]             v_q, v_n;
   logic [DEPTH-1:0]             k_q, k_n;
   logic [DEPTH-1:0][ADDR_W-1:0] a_q, a_n;
   logic [DEPTH-1:0][AGE_W-1:0]  g_q, g_n;
   logic [PTR_W-1:0]             head_q, head_n;
   logic [PTR_W-1:0]             tail;
   logic                         commit_fire;
   logic                         alloc_fire;

   always_comb begin
      count = '0;
      for (int i = 0; i < DEPTH; i++) begin
         count = count + CNT_W'(v_q[i]);
      end
      full        = (count == CNT_W'(DEPTH));
      tail        = head_q + count[PTR_W-1:0];
      commit_fire = commit_valid && (count != '0);
      alloc_fire  = alloc_valid && !flush_valid && !full;
   end

   always_comb begin
      v_n    = v_q;
      k_n    = k_q;
      a_n    = a_q;
      g_n    = g_q;
      head_n = commit_fire ? head_q + PTR_W'(1) : head_q;
      for (int i = 0; i < DEPTH; i++) begin
         if (commit_fire && (PTR_W'(i) == head_q)) begin
            v_n[i] = 1'b0;
         end
         if (flush_valid && v_q[i] &&
             age_older(32'(flush_age), 32'(g_q[i]), AGE_W)) begin
            v_n[i] = 1'b0;
         end
         if (!flush_valid && fill_valid && v_q[i] && (g_q[i] == fill_age)) begin
            k_n[i] = 1'b1;
            a_n[i] = fill_addr;
         end
      end
      if (alloc_fire) begin
         v_n[tail] = 1'b1;
         k_n[tail] = 1'b0;
         a_n[tail] = '0;
         g_n[tail] = alloc_age;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= '0;
         k_q    <= '0;
         a_q    <= '0;
         g_q    <= '0;
         head_q <= '0;
      end else begin
         v_q    <= v_n;
         k_q    <= k_n;
         a_q    <= a_n;
         g_q    <= g_n;
         head_q <= head_n;
      end
   end

   assign ent_valid = v_q;
   assign ent_known = k_q;
   assign ent_addr  = a_q;
   assign ent_age   = g_q;

   // R2
   alloc_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid && !flush_valid && !commit_valid && !full
      |=> count == $past(count) + CNT_W'(1));

   // R2
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && !commit_valid && !flush_valid |=> full);

   // R7
   commit_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid && (count != '0) && !flush_valid && !alloc_valid
      |=> count == $past(count) - CNT_W'(1));

   // R7
   commit_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid && (count != '0) |-> k_q[head_q]);

   // R8
   flush_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> count <= $past(count));

endmodule

// File: rtl/ldst_dep_check.sv
module ldst_dep_check
   import ldst_dep_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int AGE_W  = 6,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_alloc_valid,
   input  logic [AGE_W-1:0]  st_alloc_age,
   input  logic              st_addr_valid,
   input  logic [AGE_W-1:0]  st_addr_age,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              st_commit,
   input  logic              flush_valid,
   input  logic [AGE_W-1:0]  flush_age,
   input  logic              ld_valid,
   input  logic [AGE_W-1:0]  ld_age,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_grant,
   output logic              ld_stall_unknown,
   output logic              ld_stall_match,
   output logic [CNT_W-1:0]  sq_count,
   output logic              sq_full
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ldst_dep_check: DEPTH must be a power of two, at least 2");
   end
   if (AGE_W < $clog2(DEPTH) + 3 || AGE_W > 32) begin : g_bad_age
      $error("ldst_dep_check: AGE_W must exceed twice the in-flight window");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ldst_dep_check: ADDR_W must be positive");
   end

   logic [DEPTH-1:0]             e_valid;
   logic [DEPTH-1:0]             e_known;
   logic [DEPTH-1:0][ADDR_W-1:0] e_addr;
   logic [DEPTH-1:0][AGE_W-1:0]  e_age;
   logic [DEPTH-1:0]             hz_unk;
   logic [DEPTH-1:0]             hz_mat;

   sq_store_ring #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .AGE_W  (AGE_W)
   ) u_ring (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_valid  (st_alloc_valid),
      .alloc_age    (st_alloc_age),
      .fill_valid   (st_addr_valid),
      .fill_age     (st_addr_age),
      .fill_addr    (st_addr),
      .commit_valid (st_commit),
      .flush_valid  (flush_valid),
      .flush_age    (flush_age),
      .ent_valid    (e_valid),
      .ent_known    (e_known),
      .ent_addr     (e_addr),
      .ent_age      (e_age),
      .count        (sq_count),
      .full         (sq_full)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_hz
      sq_entry_hazard #(
         .ADDR_W (ADDR_W),
         .AGE_W  (AGE_W)
      ) u_hz (
         .ent_valid  (e_valid[i]),
         .ent_known  (e_known[i]),
         .ent_addr   (e_addr[i]),
         .ent_age    (e_age[i]),
         .ld_age     (ld_age),
         .ld_addr    (ld_addr),
         .hz_unknown (hz_unk[i]),
         .hz_match   (hz_mat[i])
      );
   end

   always_comb begin
      ld_stall_unknown = ld_valid && (|hz_unk);
      ld_stall_match   = ld_valid && (|hz_mat);
      ld_grant         = ld_valid && !(|hz_unk) && !(|hz_mat);
   end

   // R1
   empty_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_count == '0) |-> (ld_grant == ld_valid));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> !ld_grant && !ld_stall_unknown && !ld_stall_match);

   // R3
   grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_grant |-> !ld_stall_unknown && !ld_stall_match);

endmodule

// File: tb/tb_ldst_dep_check.sv
module tb_ldst_dep_check;

   localparam int DEPTH  = 8;
   localparam int ADDR_W = 16;
   localparam int AGE_W  = 6;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n;
   logic              st_alloc_valid;
   logic [AGE_W-1:0]  st_alloc_age;
   logic              st_addr_valid;
   logic [AGE_W-1:0]  st_addr_age;
   logic [ADDR_W-1:0] st_addr;
   logic              st_commit;
   logic              flush_valid;
   logic [AGE_W-1:0]  flush_age;
   logic              ld_valid;
   logic [AGE_W-1:0]  ld_age;
   logic [ADDR_W-1:0] ld_addr;
   logic              ld_grant;
   logic              ld_stall_unknown;
   logic              ld_stall_match;
   logic [CNT_W-1:0]  sq_count;
   logic              sq_full;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // model of the queue, index 0 is oldest
   logic [AGE_W-1:0]  m_age   [DEPTH];
   logic              m_known [DEPTH];
   logic [ADDR_W-1:0] m_addr  [DEPTH];
   int                m_cnt = 0;
   logic [AGE_W-1:0]  next_age = '0;

   always #5 clk = ~clk;

   ldst_dep_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .st_alloc_valid(st_alloc_valid), .st_alloc_age(st_alloc_age),
      .st_addr_valid(st_addr_valid), .st_addr_age(st_addr_age), .st_addr(st_addr),
      .st_commit(st_commit), .flush_valid(flush_valid), .flush_age(flush_age),
      .ld_valid(ld_valid), .ld_age(ld_age), .ld_addr(ld_addr),
      .ld_grant(ld_grant), .ld_stall_unknown(ld_stall_unknown),
      .ld_stall_match(ld_stall_match), .sq_count(sq_count), .sq_full(sq_full)
   );

   // R9: older when the wrapped difference has its top bit set
   function automatic bit older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = a - b;
      return d[AGE_W-1];
   endfunction

   function automatic bit exp_unknown();
      bit r = 0;
      for (int i = 0; i < m_cnt; i++)
         if (older(m_age[i], ld_age) && !m_known[i]) r = 1;
      return ld_valid && r;
   endfunction

   function automatic bit exp_match();
      bit r = 0;
      for (int i = 0; i < m_cnt; i++)
         if (older(m_age[i], ld_age) && m_known[i] && m_addr[i] == ld_addr) r = 1;
      return ld_valid && r;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic clr();
      st_alloc_valid = 0; st_alloc_age = '0;
      st_addr_valid = 0; st_addr_age = '0; st_addr = '0;
      st_commit = 0; flush_valid = 0; flush_age = '0;
      ld_valid = 0; ld_age = '0; ld_addr = '0;
   endtask

   task automatic model_update();
      bit cfire, afire;
      int n;
      cfire = st_commit && m_cnt > 0;
      afire = st_alloc_valid && !flush_valid && m_cnt < DEPTH;
      if (!flush_valid && st_addr_valid)
         for (int i = 0; i < m_cnt; i++)
            if (m_age[i] == st_addr_age) begin
               m_known[i] = 1; m_addr[i] = st_addr;
            end
      if (afire) begin
         m_age[m_cnt] = st_alloc_age; m_known[m_cnt] = 0; m_addr[m_cnt] = '0;
         m_cnt++;
      end
      if (cfire) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            m_age[i] = m_age[i+1]; m_known[i] = m_known[i+1]; m_addr[i] = m_addr[i+1];
         end
         m_cnt--;
      end
      if (flush_valid) begin
         n = 0;
         for (int i = 0; i < m_cnt; i++)
            if (!older(flush_age, m_age[i])) n = i + 1;
         m_cnt = n;
      end
   endtask

   // inputs already driven after a negedge; check, clock, update model
   task automatic step(input string gtag);
      #2;
      chk({gtag, " grant"}, ld_grant, ld_valid && !exp_unknown() && !exp_match());
      chk("R3 stall_unknown", ld_stall_unknown, exp_unknown());
      chk("R4 stall_match", ld_stall_match, exp_match());
      chk("R2 count", sq_count, m_cnt);
      chk("R2 full", sq_full, m_cnt == DEPTH);
      @(posedge clk);
      #1;
      model_update();
      @(negedge clk);
      clr();
   endtask

   task automatic alloc_one();
      st_alloc_valid = 1; st_alloc_age = next_age;
      if (m_cnt < DEPTH && !flush_valid) next_age = next_age + 2;
   endtask

   initial begin
      clr();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R1: reset state, load granted on empty queue
      ld_valid = 1; ld_age = 6'd5; ld_addr = 16'd3;
      step("R1");

      // R2: allocate store age 0
      alloc_one();
      step("R2");
      // R3: older unknown store blocks
      ld_valid = 1; ld_age = 6'd1; ld_addr = 16'd5;
      step("R3");
      // R5: store younger than load is ignored
      ld_valid = 1; ld_age = 6'd63; ld_addr = 16'd5;
      step("R5");
      // R6: fill in this cycle, decision unchanged until next edge
      st_addr_valid = 1; st_addr_age = 6'd0; st_addr = 16'd5;
      ld_valid = 1; ld_age = 6'd1; ld_addr = 16'd5;
      step("R6");
      // R4: now known and matching
      ld_valid = 1; ld_age = 6'd1; ld_addr = 16'd5;
      step("R4");
      // R11: known but different address
      ld_valid = 1; ld_age = 6'd1; ld_addr = 16'd6;
      step("R11");
      // R6: fill of an age not queued is ignored
      st_addr_valid = 1; st_addr_age = 6'd40; st_addr = 16'd6;
      step("R6");
      // R10: no load, no outputs
      ld_valid = 0; ld_age = 6'd1; ld_addr = 16'd5;
      step("R10");

      // R2: fill to full, then allocation ignored
      for (int i = 0; i < DEPTH; i++) begin
         alloc_one();
         step("R2");
      end
      ld_valid = 1; ld_age = 6'd63; ld_addr = 16'd5;
      step("R5");

      // R8: flush keeps ages 0..6, allocation in same cycle ignored
      flush_valid = 1; flush_age = 6'd6;
      alloc_one();
      step("R8");
      next_age = 6'd8;
      ld_valid = 1; ld_age = 6'd9; ld_addr = 16'd5;
      step("R8");

      // R7: resolve remaining addresses and commit until empty
      for (int i = 1; i < 4; i++) begin
         st_addr_valid = 1; st_addr_age = AGE_W'(2 * i); st_addr = 16'd7;
         step("R6");
      end
      for (int i = 0; i < 5; i++) begin
         st_commit = 1;
         ld_valid = 1; ld_age = 6'd7; ld_addr = 16'd7;
         step("R7");
      end

      // R9: stores on both sides of the wrap point
      next_age = 6'd60;
      for (int i = 0; i < 3; i++) begin
         alloc_one();
         step("R9");
      end
      st_addr_valid = 1; st_addr_age = 6'd0; st_addr = 16'd9;
      step("R9");
      ld_valid = 1; ld_age = 6'd63; ld_addr = 16'd9;
      step("R9");
      st_addr_valid = 1; st_addr_age = 6'd60; st_addr = 16'd1;
      step("R9");
      st_addr_valid = 1; st_addr_age = 6'd62; st_addr = 16'd1;
      step("R9");
      ld_valid = 1; ld_age = 6'd63; ld_addr = 16'd9;
      step("R9");
      ld_valid = 1; ld_age = 6'd1; ld_addr = 16'd9;
      step("R9");
      flush_valid = 1; flush_age = 6'd59;
      step("R8");
      next_age = 6'd60;

      // constrained random mix
      void'($urandom(32'd1234));
      for (int c = 0; c < 4000; c++) begin
         logic [AGE_W-1:0] base;
         int k;
         base = (m_cnt > 0) ? m_age[0] : next_age;
         if ($urandom % 25 == 0) begin
            k = $urandom % (m_cnt + 1);
            flush_valid = 1;
            flush_age = (k == 0) ? base - 1 : m_age[k-1];
         end
         if ($urandom % 3 == 0) begin
            st_alloc_valid = 1; st_alloc_age = next_age;
         end
         if (m_cnt > 0 && $urandom % 2 == 0) begin
            k = $urandom % m_cnt;
            st_addr_valid = 1;
            st_addr_age = ($urandom % 10 == 0) ? next_age + 1 : m_age[k];
            st_addr = ADDR_W'($urandom % 4);
         end
         if (m_cnt > 0 && m_known[0] && $urandom % 3 == 0) st_commit = 1;
         if ($urandom % 8 != 0) begin
            k = $urandom % (m_cnt + 1);
            ld_valid = 1;
            ld_age = base - 1 + AGE_W'(2 * k);
            ld_addr = ADDR_W'($urandom % 4);
         end
         // next store age follows the accepted operation
         if (flush_valid)
            next_age = flush_age[0] ? flush_age + 1 : flush_age + 2;
         else if (st_alloc_valid && m_cnt < DEPTH)
            next_age = next_age + 2;
         step("R5");
      end

      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule